// File: doc/BRIEF.md
# Integer Load Address and Writeback Unit

This unit takes one decoded integer load at a time and turns it into a single memory read and the register writes that follow it. A request carries the base and destination register numbers, the base register value, an index register value, a 16-bit displacement, an address mode, an access size, an update flag, the byte-order mode and a flag that marks load-multiple and string operations. The unit forms a 32-bit effective address and checks the request for invalid update forms and for alignment faults. If the request is clean, the unit issues the read. When the read data comes back, the unit zero-extends the byte, halfword or word and presents it for the destination register. In the same cycle it presents the effective address for the base register when the request is an update form.

A request that faults issues no read and writes no register. Instead the unit gives a one-cycle exception pulse with a cause code and stays ready for the next request. The register file, the memory and the decoder are outside the unit. Requests use a valid/ready handshake, and only one request is in flight at a time.

Top module: `ldwb_unit`

## Requirements
- R1: The effective address is base + sign-extended 16-bit displacement when `req_amode`=0, base + index when `req_amode`=1, and the base alone when `req_amode`=2 or 3. For a request without update, base register number 0 uses a literal zero as the base instead of `req_base_val`.
- R2: The cycle after a clean request is accepted, `mem_rd_valid` rises with `mem_rd_addr` equal to the effective address and `mem_rd_size` equal to `req_size`. All three stay unchanged until the cycle in which `mem_rd_ready` is high.
- R3: The destination data is zero-extended from the low bits of `mem_rsp_data`: 8 bits for size 0, 16 bits for size 1, and all 32 bits for size 2 or 3. It appears with `wb_dst_en` high for one cycle, in the cycle after `mem_rsp_valid` is seen.
- R4: For a clean update request, `wb_base_en` is high in the same cycle as `wb_dst_en`, and `wb_base_data` equals the effective address. For a request without update, `wb_base_en` stays low.
- R5: An update request whose base register number is 0, or equals the destination register number, is an invalid form. It gives `exc_cause`=2, issues no read and raises no writeback enable.
- R6: In big-endian mode (`req_le`=0), a misaligned access gives `exc_cause`=1 with no read. Misaligned means address bit 0 is set for a halfword, or either of address bits 1:0 is set for a word.
- R7: In little-endian mode, a misaligned access that is not multiple/string completes as a normal read with no exception.
- R8: In little-endian mode, a multiple/string request (`req_multi`=1) gives `exc_cause`=1 even when the address is aligned. An aligned multiple/string request in big-endian mode proceeds normally.
- R9: A faulty request raises `exc_valid` for exactly one cycle, the cycle after acceptance, with `req_ready` still high. When a request is both an invalid form and misaligned, cause 2 is reported.
- R10: `req_ready` is low from the cycle after a clean request is accepted until the cycle after its writeback cycle.
- R11: After reset, `req_ready` is high, and `mem_rd_valid`, `wb_dst_en`, `wb_base_en` and `exc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_base_idx | input | 5 | Base register number |
| req_dst_idx | input | 5 | Destination register number |
| req_base_val | input | 32 | Base register contents |
| req_idx_val | input | 32 | Index register contents |
| req_disp | input | 16 | Signed displacement |
| req_amode | input | 2 | 0 base+disp, 1 base+index, 2/3 base only |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_update | input | 1 | Update form: write the address to the base register |
| req_le | input | 1 | Little-endian mode |
| req_multi | input | 1 | Load-multiple or string operation |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Read address |
| mem_rd_size | output | 2 | Read size |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data, element right-justified |
| wb_dst_en | output | 1 | Destination write enable |
| wb_dst_idx | output | 5 | Destination register number |
| wb_dst_data | output | 32 | Zero-extended load data |
| wb_base_en | output | 1 | Base write enable |
| wb_base_idx | output | 5 | Base register number |
| wb_base_data | output | 32 | Effective address |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 2 | 1 alignment, 2 invalid form |

## Verification
The address path is driven with a positive and a negative displacement, an index register, the base alone, and base register 0 carrying a nonzero value. Together these separate sign extension, mode selection and the literal-zero rule. The memory model returns nonzero upper bits, so a byte or halfword load that does not mask them shows up. A stalled read checks that the request is held. Misaligned halfword and word addresses are applied in both byte orders, and aligned multiple/string requests are applied in both byte orders. This separates the big-endian misalignment trap, the little-endian permission and the little-endian multiple/string trap. Update requests with base register 0, with base equal to destination, and with a fault of both kinds at once check the cause codes and their priority.

// File: rtl/ldwb_pkg.sv
package ldwb_pkg;
  localparam int XLEN  = 32;
  localparam int REGW  = 5;
  localparam int DISPW = 16;

  localparam logic [1:0] AM_DISP  = 2'd0;
  localparam logic [1:0] AM_INDEX = 2'd1;
  localparam logic [1:0] AM_BASE  = 2'd2;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_ALIGN = 2'd1;
  localparam logic [1:0] CAUSE_FORM  = 2'd2;

  // Address arithmetic for the three modes; codes other than disp/index use the base alone.
  function automatic logic [XLEN-1:0] ea_sum(input logic [XLEN-1:0] base,
                                             input logic [XLEN-1:0] idx,
                                             input logic [DISPW-1:0] disp,
                                             input logic [1:0] amode);
    case (amode)
      AM_DISP:  ea_sum = base + {{(XLEN-DISPW){disp[DISPW-1]}}, disp};
      AM_INDEX: ea_sum = base + idx;
      default:  ea_sum = base;
    endcase
  endfunction

  function automatic logic misaligned(input logic [1:0] lo, input logic [1:0] size);
    case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = lo[0];
      default: misaligned = |lo;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] zext(input logic [XLEN-1:0] raw, input logic [1:0] size);
    case (size)
      SZ_BYTE: zext = {{(XLEN-8){1'b0}}, raw[7:0]};
      SZ_HALF: zext = {{(XLEN-16){1'b0}}, raw[15:0]};
      default: zext = raw;
    endcase
  endfunction
endpackage

// File: rtl/ldwb_addr.sv
module ldwb_addr
  import ldwb_pkg::*;
#(
  parameter int AW   = XLEN,
  parameter int RW   = REGW,
  parameter int DW_D = DISPW
) (
  input  logic [RW-1:0]   base_idx,
  input  logic [RW-1:0]   dst_idx,
  input  logic [AW-1:0]   base_val,
  input  logic [AW-1:0]   idx_val,
  input  logic [DW_D-1:0] disp,
  input  logic [1:0]      amode,
  input  logic [1:0]      size,
  input  logic            update,
  input  logic            le,
  input  logic            multi,
  output logic [AW-1:0]   ea,
  output logic            form_bad,
  output logic            align_bad,
  output logic [1:0]      cause
);
  logic          base_is_r0;
  logic [AW-1:0] base_eff;

  assign base_is_r0 = (base_idx == '0);
  // Register 0 as base means literal zero for forms without update.
  assign base_eff   = (base_is_r0 && !update) ? '0 : base_val;
  assign ea         = ea_sum(base_eff, idx_val, disp, amode);

  assign form_bad  = update && (base_is_r0 || (base_idx == dst_idx));
  // Little-endian: single-register misalignment allowed, multiple/string trapped.
  assign align_bad = le ? multi : misaligned(ea[1:0], size);

  always_comb begin
    if (form_bad)       cause = CAUSE_FORM;
    else if (align_bad) cause = CAUSE_ALIGN;
    else                cause = CAUSE_NONE;
  end

  always_comb begin
    if (le && !multi && !form_bad)
      AST_LE_SINGLE_NOTRAP: assert (cause == CAUSE_NONE); // R7
  end
endmodule

// File: rtl/ldwb_zext.sv
module ldwb_zext
  import ldwb_pkg::*;
#(
  parameter int AW = XLEN
) (
  input  logic [AW-1:0] raw,
  input  logic [1:0]    size,
  output logic [AW-1:0] data
);
  assign data = zext(raw, size);
endmodule

// File: rtl/ldwb_unit.sv
module ldwb_unit
  import ldwb_pkg::*;
#(
  parameter int AW   = XLEN,
  parameter int RW   = REGW,
  parameter int DW_D = DISPW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [RW-1:0]   req_base_idx,
  input  logic [RW-1:0]   req_dst_idx,
  input  logic [AW-1:0]   req_base_val,
  input  logic [AW-1:0]   req_idx_val,
  input  logic [DW_D-1:0] req_disp,
  input  logic [1:0]      req_amode,
  input  logic [1:0]      req_size,
  input  logic            req_update,
  input  logic            req_le,
  input  logic            req_multi,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [AW-1:0]   mem_rd_addr,
  output logic [1:0]      mem_rd_size,
  input  logic            mem_rsp_valid,
  input  logic [AW-1:0]   mem_rsp_data,
  output logic            wb_dst_en,
  output logic [RW-1:0]   wb_dst_idx,
  output logic [AW-1:0]   wb_dst_data,
  output logic            wb_base_en,
  output logic [RW-1:0]   wb_base_idx,
  output logic [AW-1:0]   wb_base_data,
  output logic            exc_valid,
  output logic [1:0]      exc_cause
);
  typedef enum logic [1:0] {S_IDLE, S_RDREQ, S_RDWAIT, S_WB} state_t;
  state_t state;

  logic [AW-1:0] ea_w, ext_w;
  logic          form_bad_w, align_bad_w;
  logic [1:0]    cause_w;

  logic [AW-1:0] addr_q, data_q;
  logic [1:0]    size_q, cause_q;
  logic [RW-1:0] base_idx_q, dst_idx_q;
  logic          upd_q, exc_q;

  // Named events for assertions.
  logic ev_accept, ev_fault, ev_issue, ev_rsp;

  ldwb_addr #(.AW(AW), .RW(RW), .DW_D(DW_D)) u_addr (
    .base_idx (req_base_idx), .dst_idx (req_dst_idx),
    .base_val (req_base_val), .idx_val (req_idx_val),
    .disp     (req_disp),     .amode   (req_amode),
    .size     (req_size),     .update  (req_update),
    .le       (req_le),       .multi   (req_multi),
    .ea       (ea_w),         .form_bad(form_bad_w),
    .align_bad(align_bad_w),  .cause   (cause_w)
  );

  ldwb_zext #(.AW(AW)) u_zext (
    .raw (mem_rsp_data), .size(size_q), .data(ext_w)
  );

  assign req_ready = (state == S_IDLE);
  assign ev_accept = req_valid && req_ready;
  assign ev_fault  = form_bad_w || align_bad_w;
  assign ev_issue  = (state == S_RDREQ) && mem_rd_ready;
  assign ev_rsp    = (state == S_RDWAIT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      addr_q     <= '0;
      data_q     <= '0;
      size_q     <= SZ_BYTE;
      cause_q    <= CAUSE_NONE;
      base_idx_q <= '0;
      dst_idx_q  <= '0;
      upd_q      <= 1'b0;
      exc_q      <= 1'b0;
    end else begin
      exc_q <= ev_accept && ev_fault;
      case (state)
        S_IDLE: if (ev_accept) begin
          if (ev_fault) begin
            cause_q <= cause_w;
          end else begin
            state      <= S_RDREQ;
            addr_q     <= ea_w;
            size_q     <= req_size;
            upd_q      <= req_update;
            base_idx_q <= req_base_idx;
            dst_idx_q  <= req_dst_idx;
          end
        end
        S_RDREQ:  if (ev_issue) state <= S_RDWAIT;
        S_RDWAIT: if (ev_rsp) begin
          data_q <= ext_w;
          state  <= S_WB;
        end
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_valid = (state == S_RDREQ);
  assign mem_rd_addr  = addr_q;
  assign mem_rd_size  = size_q;
  assign wb_dst_en    = (state == S_WB);
  assign wb_dst_idx   = dst_idx_q;
  assign wb_dst_data  = data_q;
  assign wb_base_en   = (state == S_WB) && upd_q;
  assign wb_base_idx  = base_idx_q;
  assign wb_base_data = addr_q;
  assign exc_valid    = exc_q;
  assign exc_cause    = cause_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr) && $stable(mem_rd_size)); // R2
  AST_ZEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_dst_en && (mem_rd_size == SZ_BYTE) |-> (wb_dst_data[AW-1:8] == '0)); // R3
  AST_ZEXT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    wb_dst_en && (mem_rd_size == SZ_HALF) |-> (wb_dst_data[AW-1:16] == '0)); // R3
  AST_BASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_base_en |-> wb_dst_en && (wb_base_idx != '0) && (wb_base_idx != wb_dst_idx)); // R5
  AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !mem_rd_valid && !wb_dst_en && req_ready && (exc_cause != CAUSE_NONE)); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && !ev_fault |=> !req_ready && mem_rd_valid); // R10
endmodule

// File: tb/ldwb_unit_bench.sv
module ldwb_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [4:0]  req_base_idx, req_dst_idx;
  logic [31:0] req_base_val, req_idx_val;
  logic [15:0] req_disp;
  logic [1:0]  req_amode, req_size;
  logic        req_update, req_le, req_multi;
  logic        mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic [1:0]  mem_rd_size;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        wb_dst_en, wb_base_en, exc_valid;
  logic [4:0]  wb_dst_idx, wb_base_idx;
  logic [31:0] wb_dst_data, wb_base_data;
  logic [1:0]  exc_cause;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ldwb_unit u_ldwb_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base_idx(req_base_idx), .req_dst_idx(req_dst_idx),
    .req_base_val(req_base_val), .req_idx_val(req_idx_val), .req_disp(req_disp),
    .req_amode(req_amode), .req_size(req_size), .req_update(req_update),
    .req_le(req_le), .req_multi(req_multi),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_size(mem_rd_size),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wb_dst_en(wb_dst_en), .wb_dst_idx(wb_dst_idx), .wb_dst_data(wb_dst_data),
    .wb_base_en(wb_base_en), .wb_base_idx(wb_base_idx), .wb_base_data(wb_base_data),
    .exc_valid(exc_valid), .exc_cause(exc_cause)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Memory model contents: upper half deliberately nonzero.
  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return {a[15:0] ^ 16'hC35A, ~a[15:0]};
  endfunction

  function automatic logic [31:0] keep_low(input logic [31:0] v, input logic [1:0] sz);
    int bits;
    bits = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    return (bits == 32) ? v : (v & ((32'd1 << bits) - 32'd1));
  endfunction

  task automatic drive(input logic [4:0] ra, input logic [4:0] rd, input logic [31:0] bv,
                       input logic [31:0] iv, input logic [15:0] d, input logic [1:0] am,
                       input logic [1:0] sz, input logic up, input logic le, input logic mu);
    @(negedge clk);
    req_valid = 1'b1; req_base_idx = ra; req_dst_idx = rd; req_base_val = bv;
    req_idx_val = iv; req_disp = d; req_amode = am; req_size = sz;
    req_update = up; req_le = le; req_multi = mu;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_load(input string tag, input logic [4:0] ra, input logic [4:0] rd,
                          input logic [31:0] bv, input logic [31:0] iv, input logic [15:0] d,
                          input logic [1:0] am, input logic [1:0] sz, input logic up,
                          input logic le, input logic mu, input logic [31:0] exp_ea,
                          input int stall);
    drive(ra, rd, bv, iv, d, am, sz, up, le, mu);
    check({tag, " R10 busy"}, {31'd0, req_ready}, 32'd0);
    check({tag, " R2 rd_valid"}, {31'd0, mem_rd_valid}, 32'd1);
    check({tag, " R1 ea"}, mem_rd_addr, exp_ea);
    check({tag, " R2 size"}, {30'd0, mem_rd_size}, {30'd0, sz});
    check({tag, " R9 no exc"}, {31'd0, exc_valid}, 32'd0);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check({tag, " R2 held valid"}, {31'd0, mem_rd_valid}, 32'd1);
      check({tag, " R2 held addr"}, mem_rd_addr, exp_ea);
    end
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    check({tag, " R2 dropped"}, {31'd0, mem_rd_valid}, 32'd0);
    mem_rsp_valid = 1'b1;
    mem_rsp_data = mem_val(exp_ea);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data = 32'hFFFF_FFFF;
    check({tag, " R3 dst_en"}, {31'd0, wb_dst_en}, 32'd1);
    check({tag, " R3 dst_idx"}, {27'd0, wb_dst_idx}, {27'd0, rd});
    check({tag, " R3 data"}, wb_dst_data, keep_low(mem_val(exp_ea), sz));
    check({tag, " R4 base_en"}, {31'd0, wb_base_en}, {31'd0, up});
    if (up) begin
      check({tag, " R4 base_idx"}, {27'd0, wb_base_idx}, {27'd0, ra});
      check({tag, " R4 base_data"}, wb_base_data, exp_ea);
    end
    check({tag, " R10 still busy"}, {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    check({tag, " R3 dst_en pulse"}, {31'd0, wb_dst_en}, 32'd0);
    check({tag, " R10 ready again"}, {31'd0, req_ready}, 32'd1);
  endtask

  task automatic run_fault(input string tag, input logic [4:0] ra, input logic [4:0] rd,
                           input logic [31:0] bv, input logic [15:0] d, input logic [1:0] sz,
                           input logic up, input logic le, input logic mu,
                           input logic [1:0] exp_cause);
    drive(ra, rd, bv, 32'h0, d, 2'd0, sz, up, le, mu);
    check({tag, " R9 exc"}, {31'd0, exc_valid}, 32'd1);
    check({tag, " cause"}, {30'd0, exc_cause}, {30'd0, exp_cause});
    check({tag, " R9 no read"}, {31'd0, mem_rd_valid}, 32'd0);
    check({tag, " R9 ready"}, {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    check({tag, " R9 pulse"}, {31'd0, exc_valid}, 32'd0);
    check({tag, " R5 no read later"}, {31'd0, mem_rd_valid}, 32'd0);
    check({tag, " R5 no wb"}, {30'd0, wb_dst_en, wb_base_en}, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0;
    mem_rsp_data = '0; req_base_idx = '0; req_dst_idx = '0; req_base_val = '0;
    req_idx_val = '0; req_disp = '0; req_amode = '0; req_size = '0;
    req_update = 1'b0; req_le = 1'b0; req_multi = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R11 ready", {31'd0, req_ready}, 32'd1);
    check("R11 quiet", {28'd0, mem_rd_valid, wb_dst_en, wb_base_en, exc_valid}, 32'd0);
  endtask

  initial begin
    t_reset();
    run_load("pos disp byte", 5'd3, 5'd7, 32'h0000_1000, 32'h0, 16'h0010, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_1010, 0);
    run_load("neg disp half", 5'd3, 5'd8, 32'h0000_2000, 32'h0, 16'hFFFE, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0000_1FFE, 0);
    run_load("index word stall", 5'd9, 5'd2, 32'h0000_3000, 32'h24, 16'h7777, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0000_3024, 3);
    run_load("base only", 5'd9, 5'd2, 32'h0000_4008, 32'h100, 16'h0040, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0000_4008, 0);
    run_load("r0 literal zero", 5'd0, 5'd6, 32'hDEAD_0000, 32'h0, 16'h0040, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0000_0040, 0);
    run_load("update word", 5'd4, 5'd5, 32'h0000_5000, 32'h0, 16'h0008, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0000_5008, 1);
    run_fault("R5 update rA0", 5'd0, 5'd5, 32'h0000_5000, 16'h0008, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2);
    run_fault("R5 update rA=rD", 5'd6, 5'd6, 32'h0000_5000, 16'h0008, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2);
    run_fault("R6 BE half odd", 5'd3, 5'd4, 32'h0000_1000, 16'h0001, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1);
    run_fault("R6 BE word off2", 5'd3, 5'd4, 32'h0000_1000, 16'h0002, 2'd2, 1'b0, 1'b0, 1'b0, 2'd1);
    run_load("R7 LE word off3", 5'd3, 5'd4, 32'h0000_1000, 32'h0, 16'h0003, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0000_1003, 0);
    run_load("R7 LE half odd upd", 5'd10, 5'd11, 32'h0000_6000, 32'h0, 16'h0005, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 32'h0000_6005, 0);
    run_fault("R8 LE multi aligned", 5'd3, 5'd4, 32'h0000_1000, 16'h0010, 2'd2, 1'b0, 1'b1, 1'b1, 2'd1);
    run_load("R8 BE multi aligned", 5'd3, 5'd4, 32'h0000_1000, 32'h0, 16'h0010, 2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0000_1010, 0);
    run_fault("R9 priority form", 5'd7, 5'd7, 32'h0000_1000, 16'h0002, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog R10 act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule